// File: doc/BRIEF.md
# Peripheral Clock Selector with Half-Step Divider

This block produces the clock-enable stream for one peripheral. A single 32-bit configuration word, loaded through a plain write port, picks one of several parent tick sources and holds an 8-bit divisor. The divisor is read as a 7.1 fixed-point value with an offset of 2. The output therefore carries, on average, `2 / (D + 2)` output ticks per parent tick. This gives ratios from 1.0 up to 128.5 in half steps. All parents are single-cycle tick-enable inputs in the same system clock domain as the block.

The parameter `WIDE_SEL` picks the variant. When `WIDE_SEL = 0` the select is a 2-bit field in bits 31:30 and there are four parents. When `WIDE_SEL = 1` the select is a 4-bit field in bits 31:28 and there are five parents; the fifth parent is the slow 32 kHz-derived tick. Division uses a half-step accumulator. Each selected parent tick adds 2 to the accumulator. When the sum reaches `D + 2`, that amount is taken off and one output tick is issued.

A small control state machine guards reconfiguration. It has two states. `ST_RUN` is the reset state and the only state in which ticks are produced. `ST_FAULT` is entered by the transition *bad-select write*, which is a write whose select field names no parent. It is left by the transition *good-select write*. A write in `ST_RUN` with a good select stays in `ST_RUN`, and a bad-select write in `ST_FAULT` stays in `ST_FAULT`. Software normally writes the divisor first and the select afterwards. Any write that changes either field restarts the count from zero.

Top module: `pcs_clk_sel`

## Requirements
- R1: After reset `cfg_rdata` is 0, and `clk_tick` and `sel_err` are low. `cfg_rdata` returns all 32 bits of the last written word from the cycle after the write.
- R2: The divisor D is bits 7:0 of the word. With D = 0 every selected parent tick gives one output tick.
- R3: After a write that restarts the count, the n-th output tick comes on parent tick number ceil(n·(D+2)/2). Over 2·(D+2) parent ticks exactly 4 output ticks appear; this holds for the odd values D = 1 and D = 255 as well.
- R4: An output tick is a single-cycle pulse. It is high in the cycle after the clock edge that samples the parent tick which completes it.
- R5: With `WIDE_SEL = 0`, the select is bits 31:30 and the value k picks `par_tick[k]`. Bits 29:28 have no effect.
- R6: With `WIDE_SEL = 1`, the select is bits 31:28 and values 0 to 4 pick `par_tick[0..4]`. Value 4 is the slow source.
- R7: A write with a select of 5 to 15 (wide variant) raises `sel_err` from the next cycle and stops all output ticks. The flag stays high through further bad-select writes.
- R8: The next write with a valid select clears `sel_err` from the next cycle, and ticks resume.
- R9: A write that changes the select or the divisor clears the count. A parent tick in the write cycle is discarded, and `clk_tick` is low in the next cycle.
- R10: A divisor-only write, made while the old source is still selected, takes effect from a zero count. The select write that follows restarts the count again on the new parent.
- R11: Bits outside the divisor and select fields have no effect. A write that leaves both fields unchanged does not disturb the count, and a parent tick in that cycle is counted.
- R12: Ticks on parents that are not selected have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| par_tick | input | NUM_PAR (5 or 4) | Parent tick enables, one per source |
| clk_tick | output | 1 | Divided output tick |
| sel_err | output | 1 | Sticky flag for an undefined select |

## Verification
A wrong accumulator value shows as an output tick shifted from its expected parent-tick index. So the bench compares every cycle after every parent tick against the ceil formula, and any drift is caught within one output period, which is at most 129 parent ticks. A count that is not cleared on reconfiguration shows up on the first one or two ticks after a write. A missing or unwanted clear shows up at the write cycle itself, or on the first tick after it. A stuck control state shows as `sel_err` being wrong one cycle after a write, or as ticks during a fault.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int CFG_W = 32;
    localparam int DIV_W = 8;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } div_state_e;
endpackage

// File: rtl/pcs_cfg_reg.sv
module pcs_cfg_reg #(
    parameter int CFG_W   = 32,
    parameter int DIV_W   = 8,
    parameter int SEL_W   = 4,
    parameter int NUM_PAR = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [SEL_W-1:0] sel,
    output logic [DIV_W-1:0] div,
    output logic             upd,
    output logic             wr_ok,
    output logic             wr_bad
);
    localparam bit ALL_DEFINED = (NUM_PAR >= (1 << SEL_W));

    logic [SEL_W-1:0] new_sel;
    logic [DIV_W-1:0] new_div;
    logic             new_ok;

    assign new_sel = wdata[CFG_W-1 -: SEL_W];
    assign new_div = wdata[DIV_W-1:0];
    assign sel     = cfg_q[CFG_W-1 -: SEL_W];
    assign div     = cfg_q[DIV_W-1:0];

    generate
        if (ALL_DEFINED) begin : g_full
            assign new_ok = 1'b1;
        end else begin : g_part
            assign new_ok = (new_sel < SEL_W'(NUM_PAR));
        end
    endgenerate

    assign upd    = we && ((new_sel != sel) || (new_div != div));
    assign wr_ok  = we && new_ok;
    assign wr_bad = we && !new_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wdata;
        end
    end

    // R1
    cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/pcs_src_mux.sv
module pcs_src_mux #(
    parameter int SEL_W   = 4,
    parameter int NUM_PAR = 5
) (
    input  logic [NUM_PAR-1:0] par_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    logic [NUM_PAR-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_PAR; i++) begin : g_src
            assign hit[i] = par_tick[i] && (sel == SEL_W'(i));
        end
    endgenerate

    assign tick = |hit;
endmodule

// File: rtl/pcs_half_div.sv
module pcs_half_div
    import pcs_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_tick,
    input  logic [DIV_W-1:0] div,
    input  logic             clr,
    input  logic             wr_ok,
    input  logic             wr_bad,
    output logic             tick_out,
    output logic             err
);
    localparam int ACC_W = DIV_W + 1;

    div_state_e       state_q, state_d;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] div_x;
    logic             tick_q;
    logic             reach;

    assign div_x = {1'b0, div};
    assign reach = (acc_q >= div_x);

    // control state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (wr_bad) state_d = ST_FAULT;
            ST_FAULT: if (wr_ok)  state_d = ST_RUN;
            default:  state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // accumulator and output tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (clr) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (state_q == ST_RUN && par_tick) begin
            if (reach) begin
                acc_q  <= acc_q - div_x;
                tick_q <= 1'b1;
            end else begin
                acc_q  <= acc_q + ACC_W'(2);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_out = tick_q;
    assign err      = (state_q == ST_FAULT);

    // R3
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= div_x + ACC_W'(1));

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !tick_out);

    // R2
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && div == '0 && par_tick && !clr) |=> tick_out);
endmodule

// File: rtl/pcs_clk_sel.sv
module pcs_clk_sel
    import pcs_pkg::*;
#(
    parameter bit WIDE_SEL = 1'b1,
    localparam int NUM_PAR = WIDE_SEL ? 5 : 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [NUM_PAR-1:0] par_tick,
    output logic               clk_tick,
    output logic               sel_err
);
    localparam int SEL_W = WIDE_SEL ? 4 : 2;

    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
    logic             upd, wr_ok, wr_bad, src_tick;

    pcs_cfg_reg #(
        .CFG_W(CFG_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .NUM_PAR(NUM_PAR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .cfg_q(cfg_rdata), .sel(sel), .div(div),
        .upd(upd), .wr_ok(wr_ok), .wr_bad(wr_bad)
    );

    pcs_src_mux #(.SEL_W(SEL_W), .NUM_PAR(NUM_PAR)) u_mux (
        .par_tick(par_tick), .sel(sel), .tick(src_tick)
    );

    pcs_half_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .par_tick(src_tick), .div(div),
        .clr(upd), .wr_ok(wr_ok), .wr_bad(wr_bad),
        .tick_out(clk_tick), .err(sel_err)
    );

    // R9
    reconf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !clk_tick);

    // R7
    bad_sel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> sel_err);

    // R8
    good_sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !sel_err);
endmodule

// File: tb/pcs_clk_sel_tb_top.sv
module pcs_clk_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_w = 1'b0, we_n = 1'b0;
    logic [31:0] wdata = '0;
    logic [4:0]  src = '0;
    logic [31:0] rd_w, rd_n;
    logic        tk_w, tk_n, er_w, er_n;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    pcs_clk_sel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_w), .cfg_wdata(wdata),
        .cfg_rdata(rd_w), .par_tick(src), .clk_tick(tk_w), .sel_err(er_w)
    );

    pcs_clk_sel #(.WIDE_SEL(1'b0)) dut_n (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_n), .cfg_wdata(wdata),
        .cfg_rdata(rd_n), .par_tick(src[3:0]), .clk_tick(tk_n), .sel_err(er_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(int sel, int d, logic [19:0] mid = '0);
        return {4'(sel), mid, 8'(d)};
    endfunction

    task automatic step(logic [4:0] pt);
        src = pt;
        @(negedge clk);
        src = '0;
    endtask

    task automatic wr_w(logic [31:0] d, logic [4:0] pt);
        wdata = d; we_w = 1'b1; src = pt;
        @(negedge clk);
        we_w = 1'b0; src = '0;
    endtask

    task automatic par_run(string req, int idx, int d, int n, int gap, int k0,
                           output int outs);
        outs = 0;
        for (int k = k0 + 1; k <= k0 + n; k++) begin
            step(5'(1 << idx));
            chk(req, 32'(tk_w), 32'(((2 * k) / (d + 2)) != ((2 * (k - 1)) / (d + 2))));
            outs += int'(tk_w);
            for (int g = 0; g < gap; g++) begin
                step(~5'(1 << idx));
                chk(req, 32'(tk_w), 0);
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 reset rdata", rd_w, 0);
        chk("R1 reset tick", 32'(tk_w), 0);
        chk("R1 reset err", 32'(er_w), 0);
    endtask

    task automatic t_passthru();
        int o;
        wr_w(mkw(1, 5), 5'b00000);
        wr_w(mkw(1, 0), 5'b00010);
        chk("R9 tick in write cycle dropped", 32'(tk_w), 0);
        par_run("R2 R4 R12 pass-through", 1, 0, 6, 1, 0, o);
        chk("R2 pass-through count", o, 6);
    endtask

    task automatic t_ratio(int d, int idx);
        int o;
        wr_w(mkw(7, 0), 5'b00000);
        wr_w(mkw(idx, d), 5'b00000);
        chk("R3 err clear", 32'(er_w), 0);
        par_run("R3 spacing", idx, d, 2 * (d + 2), 0, 0, o);
        chk("R3 four ticks per window", o, 4);
    endtask

    task automatic t_slow();
        int o;
        wr_w(mkw(4, 2), 5'b00000);
        par_run("R6 slow source", 4, 2, 6, 2, 0, o);
        chk("R6 slow count", o, 3);
    endtask

    task automatic t_invalid();
        int o;
        wr_w(mkw(9, 0), 5'h1F);
        chk("R7 err set", 32'(er_w), 1);
        chk("R1 rdata invalid word", rd_w, mkw(9, 0));
        for (int i = 0; i < 6; i++) begin
            step(5'h1F);
            chk("R7 no ticks", 32'(tk_w), 0);
            chk("R7 sticky", 32'(er_w), 1);
        end
        wr_w(mkw(15, 4), 5'h1F);
        chk("R7 sticky after second bad write", 32'(er_w), 1);
        wr_w(mkw(0, 0), 5'h1F);
        chk("R8 err cleared", 32'(er_w), 0);
        par_run("R8 ticks resume", 0, 0, 3, 0, 0, o);
    endtask

    task automatic t_seq();
        int o;
        wr_w(mkw(2, 0), 5'b00000);
        par_run("R10 old setting", 2, 0, 3, 0, 0, o);
        wr_w(mkw(2, 3), 5'b00100);
        chk("R9 divisor write clean", 32'(tk_w), 0);
        par_run("R10 new divisor old source", 2, 3, 5, 1, 0, o);
        wr_w(mkw(3, 3), 5'b01000);
        chk("R9 select write clean", 32'(tk_w), 0);
        par_run("R10 new source", 3, 3, 10, 0, 0, o);
        chk("R10 count", o, 4);
    endtask

    task automatic t_other();
        int o;
        wr_w(mkw(1, 3), 5'b00000);
        par_run("R11 before", 1, 3, 1, 0, 0, o);
        wr_w(mkw(1, 3, 20'hA5A5A), 5'b00010);
        chk("R11 tick counted in same-field write", 32'(tk_w), 0);
        chk("R1 rdata other bits", rd_w, mkw(1, 3, 20'hA5A5A));
        par_run("R11 count undisturbed", 1, 3, 8, 0, 2, o);
        chk("R11 count", o, 4);
    endtask

    task automatic t_narrow();
        wdata = {2'b10, 2'b11, 20'h0, 8'd0}; we_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        chk("R5 narrow no err", 32'(er_n), 0);
        chk("R5 narrow rdata", rd_n, {2'b10, 2'b11, 20'h0, 8'd0});
        step(5'b00100);
        chk("R5 selected parent 2", 32'(tk_n), 1);
        step(5'b01011);
        chk("R5 R12 other parents", 32'(tk_n), 0);
        wdata = {2'b11, 2'b00, 20'h0, 8'd1}; we_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        step(5'b01000);
        chk("R5 div1 tick1", 32'(tk_n), 0);
        step(5'b01000);
        chk("R5 div1 tick2", 32'(tk_n), 1);
        step(5'b01000);
        chk("R5 div1 tick3", 32'(tk_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthru();
        t_ratio(1, 0);
        t_ratio(2, 1);
        t_ratio(3, 2);
        t_ratio(255, 3);
        t_slow();
        t_invalid();
        t_seq();
        t_other();
        t_narrow();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule